// File: doc/BRIEF.md
# Three-Client Dual-Resource Allocation Arbiter

This block shares two resources, called A and B, among three clients. Each client runs a four-phase request/grant handshake. Client 0 uses only resource A, client 1 uses only resource B, and client 2 needs A and B together. Requests that do not compete for a resource are granted in the same cycle. A dual-resource grant is made only when both resources are idle and available at the same moment.

Each single-resource client has a saturating history counter. The counter records how many times that client has been granted its resource since client 2 was last served. When the counter is full and client 2 is waiting, the single-resource client is held off. This stops clients 0 and 1 from trading the resources back and forth while client 2 waits forever.

Each client has an attribute word. The block captures it when the client's grant is issued and holds it steady for the whole tenure. For each resource, the block takes in an availability level and drives out a one-cycle release pulse when the holder lets go.

Top module: `mra_arbiter`

## Requirements
- R1: Client 0 (bit 0 of `req`/`gnt`) maps to resource A (index 0), client 1 (bit 1) maps to resource B (index 1), and client 2 (bit 2) maps to both. A grant is registered: it appears on `gnt` in the cycle after the clock edge at which the request was seen with its resource or resources free.
- R2: At no time do two clients hold the same resource. Client 2 never holds a grant together with client 0 or client 1.
- R3: When clients 0 and 1 request and both their resources are free, both grants rise in the same cycle.
- R4: Client 2 is granted A and B together through its single grant bit. This happens only when neither resource is held by anyone and both availability inputs are high.
- R5: Once a grant is high, it stays high while the client's request stays high. The grant falls in the cycle after the edge at which the request is seen low.
- R6: `res_release[r]` is high for exactly one cycle: the cycle in which the grant of the holder of resource r has just fallen. It is low at every other time.
- R7: A single-resource client's counter counts that client's grants and stops at `HIST_K`. The counter clears when client 2 is granted. A client whose count equals `HIST_K` is not granted while client 2 has a pending request. When client 2 is idle, the count has no effect.
- R8: Client 2 and a single-resource client may both want the same free resource in one cycle. In that case the single-resource client wins, unless its count equals `HIST_K`, in which case client 2 is served.
- R9: `attr_held` slice i (bits i*ATTR_W upward) takes `attr_in` slice i at the edge that grants client i. It holds that value unchanged until the next grant of that client, whatever `attr_in` does in between.
- R10: While `rst` is high at a clock edge, all grants, release pulses, held attributes and counters go to zero.
- R11: A resource whose availability input is low is not granted to any client, whichever client asks for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Request level per client |
| attr_in | input | 3*ATTR_W | Request attribute word per client |
| res_avail | input | 2 | Availability of resource A (bit 0) and B (bit 1) |
| gnt | output | 3 | Registered grant per client |
| attr_held | output | 3*ATTR_W | Attribute words captured at grant |
| res_release | output | 2 | One-cycle pulse when resource A or B is given back |

## Verification
The bench builds the block with `HIST_K` = 2 and `ATTR_W` = 8. With this small threshold, the blocking state is reached after only two grants per single-resource client. An overlapping request pattern from clients 0 and 1 therefore reaches the point where both counters are full within about a dozen cycles, and the bench can then observe client 2 breaking through. The same setting lets the bench show both sides of the tie rule. It also lets the bench show that a full counter does nothing while client 2 is idle, since three back-to-back grants to client 0 are enough to pass the threshold.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int NCLI = 3;
  localparam int NRES = 2;
  localparam int C_A  = 0;
  localparam int C_B  = 1;
  localparam int C_AB = 2;
endpackage

// File: rtl/mra_client_slot.sv
module mra_client_slot #(
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              win,
  input  logic [ATTR_W-1:0] attr_in,
  output logic              gnt,
  output logic              want,
  output logic [ATTR_W-1:0] attr_held
);
  // A client wants service only while it is not already served
  assign want = req & ~gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt       <= 1'b0;
      attr_held <= '0;
    end else if (gnt) begin
      gnt <= req;
    end else if (win) begin
      gnt       <= 1'b1;
      attr_held <= attr_in;
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (gnt && req) |=> gnt);
  a_r5_drop: assert property (@(posedge clk) disable iff (rst)
    (gnt && !req) |=> !gnt);
  a_r1_win_grants: assert property (@(posedge clk) disable iff (rst)
    win |=> gnt);
  a_r9_attr_stable: assert property (@(posedge clk) disable iff (rst)
    (gnt && req) |=> $stable(attr_held));
endmodule

// File: rtl/mra_fair_cnt.sv
module mra_fair_cnt #(
  parameter int HIST_K = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  input  logic dual_wait,
  output logic blocked
);
  localparam int CW = $clog2(HIST_K + 1);
  localparam logic [CW-1:0] KV = CW'(HIST_K);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != KV)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign blocked = dual_wait && (cnt == KV);

  a_r7_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= KV);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/mra_res_track.sv
module mra_res_track (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] hold_gnt,
  input  logic [1:0] hold_req,
  input  logic       avail,
  output logic       free,
  output logic       release_o
);
  // Free: nobody holds the resource and it is offered
  assign free = avail & ~(|hold_gnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      release_o <= 1'b0;
    end else begin
      release_o <= |(hold_gnt & ~hold_req);
    end
  end

  a_r2_one_holder: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hold_gnt));
  a_r6_release_after_hold: assert property (@(posedge clk) disable iff (rst)
    release_o |-> ($past(|hold_gnt) && !(|hold_gnt)));
endmodule

// File: rtl/mra_arbiter.sv
module mra_arbiter
  import mra_pkg::*;
#(
  parameter int ATTR_W = 8,
  parameter int HIST_K = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCLI-1:0]        req,
  input  logic [NCLI*ATTR_W-1:0] attr_in,
  input  logic [NRES-1:0]        res_avail,
  output logic [NCLI-1:0]        gnt,
  output logic [NCLI*ATTR_W-1:0] attr_held,
  output logic [NRES-1:0]        res_release
);
  logic [NCLI-1:0] want;
  logic [NCLI-1:0] win;
  logic [NRES-1:0] free;
  logic [NRES-1:0] blk;
  logic [NRES-1:0] single_win;

  // Per-client handshake and attribute capture
  for (genvar i = 0; i < NCLI; i++) begin : g_slot
    mra_client_slot #(.ATTR_W(ATTR_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .req       (req[i]),
      .win       (win[i]),
      .attr_in   (attr_in[i*ATTR_W +: ATTR_W]),
      .gnt       (gnt[i]),
      .want      (want[i]),
      .attr_held (attr_held[i*ATTR_W +: ATTR_W])
    );
  end

  // Single client r owns resource r; the dual client shares both
  for (genvar r = 0; r < NRES; r++) begin : g_res
    mra_res_track u_trk (
      .clk       (clk),
      .rst       (rst),
      .hold_gnt  ({gnt[C_AB], gnt[r]}),
      .hold_req  ({req[C_AB], req[r]}),
      .avail     (res_avail[r]),
      .free      (free[r]),
      .release_o (res_release[r])
    );

    mra_fair_cnt #(.HIST_K(HIST_K)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .inc       (win[r]),
      .clr       (win[C_AB]),
      .dual_wait (want[C_AB]),
      .blocked   (blk[r])
    );

    assign single_win[r] = want[r] & free[r] & ~blk[r];
  end

  // Decision: single clients first unless held off by history
  always_comb begin
    win       = '0;
    win[C_A]  = single_win[C_A];
    win[C_B]  = single_win[C_B];
    win[C_AB] = want[C_AB] & (&free) & ~(|single_win);
  end

  a_r2_mutex_a: assert property (@(posedge clk) disable iff (rst)
    !(gnt[C_A] && gnt[C_AB]));
  a_r2_mutex_b: assert property (@(posedge clk) disable iff (rst)
    !(gnt[C_B] && gnt[C_AB]));
  a_r11_avail_a: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt[C_A]) |-> $past(res_avail[C_A]));
  a_r11_avail_b: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt[C_B]) |-> $past(res_avail[C_B]));
  a_r4_dual_both: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt[C_AB]) |-> $past(!gnt[C_A] && !gnt[C_B] && (&res_avail)));
  a_r6_release_a: assert property (@(posedge clk) disable iff (rst)
    ($fell(gnt[C_A]) || $fell(gnt[C_AB])) |-> res_release[C_A]);
endmodule

// File: tb/tb_mra_arbiter.sv
module tb_mra_arbiter;
  localparam int AW = 8;
  localparam int K  = 2;
  localparam int CP = 8;
  localparam int AT = 3 * AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    req;
  logic [AT-1:0] attr_in;
  logic [1:0]    res_avail;
  logic [2:0]    gnt;
  logic [AT-1:0] attr_held;
  logic [1:0]    res_release;

  always #(CP/2) clk = ~clk;

  mra_arbiter #(.ATTR_W(AW), .HIST_K(K)) dut (
    .clk(clk), .rst(rst), .req(req), .attr_in(attr_in),
    .res_avail(res_avail), .gnt(gnt), .attr_held(attr_held),
    .res_release(res_release)
  );

  typedef struct packed {
    logic [2:0]    g;
    logic [1:0]    r;
    logic [AT-1:0] a;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  // Requirement-level reference state
  logic [2:0]    mg = '0;
  logic [AT-1:0] ma = '0;
  int            mc0 = 0;
  int            mc1 = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result
  task automatic drive(input logic [2:0] r, input logic [1:0] av,
                       input logic [AT-1:0] at);
    logic fa, fb, b0, b1, e0, e1, n2;
    logic [2:0] w, ng;
    logic [1:0] nr;
    exp_t e;
    @(negedge clk);
    req = r; res_avail = av; attr_in = at;
    fa = !mg[0] && !mg[2] && av[0];
    fb = !mg[1] && !mg[2] && av[1];
    w  = r & ~mg;
    b0 = (mc0 >= K) && w[2];
    b1 = (mc1 >= K) && w[2];
    e0 = w[0] && fa && !b0;
    e1 = w[1] && fb && !b1;
    n2 = w[2] && fa && fb && !e0 && !e1;
    nr[0] = (mg[0] && !r[0]) || (mg[2] && !r[2]);
    nr[1] = (mg[1] && !r[1]) || (mg[2] && !r[2]);
    ng[0] = mg[0] ? r[0] : e0;
    ng[1] = mg[1] ? r[1] : e1;
    ng[2] = mg[2] ? r[2] : n2;
    if (e0) ma[0*AW +: AW] = at[0*AW +: AW];
    if (e1) ma[1*AW +: AW] = at[1*AW +: AW];
    if (n2) ma[2*AW +: AW] = at[2*AW +: AW];
    if (n2) begin
      mc0 = 0; mc1 = 0;
    end else begin
      if (e0 && mc0 < K) mc0++;
      if (e1 && mc1 < K) mc1++;
    end
    mg = ng;
    e.g = ng; e.r = nr; e.a = ma;
    q.push_back(e);
  endtask

  task automatic expect_g(input logic [2:0] exp, input string tag);
    @(posedge clk); #2;
    check(gnt === exp, tag, 32'(gnt), 32'(exp));
  endtask

  // Monitor: compare every cycle's outputs with the queued item
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(gnt === e.g, "R1 R3 R4 R5 R7 R8 R11 grant", 32'(gnt), 32'(e.g));
        check(res_release === e.r, "R6 release", 32'(res_release), 32'(e.r));
        check(attr_held === e.a, "R9 attribute", attr_held, e.a);
        check(!(gnt[2] && (gnt[0] || gnt[1])), "R2 mutual exclusion",
              32'(gnt), 32'(gnt & 3'b011));
      end
    end
  end

  task automatic run_all();
    bit served;
    rst = 1'b1; req = '0; res_avail = '0; attr_in = '0;
    repeat (3) @(negedge clk);
    check(gnt === 3'b000, "R10 reset grant", 32'(gnt), 0);
    check(res_release === 2'b00, "R10 reset release", 32'(res_release), 0);
    check(attr_held === '0, "R10 reset attribute", attr_held, 0);
    rst = 1'b0;

    // R3: independent clients granted together
    drive(3'b011, 2'b11, 24'h00_22_11);
    expect_g(3'b011, "R3 pair granted together");
    drive(3'b011, 2'b11, 24'h00_99_88);
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);

    // R4: dual client alone takes both
    drive(3'b100, 2'b11, 24'h33_00_00);
    expect_g(3'b100, "R4 dual grant");
    drive(3'b100, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);

    // R8: tie with count below threshold goes to single client
    drive(3'b101, 2'b11, 24'h44_00_55);
    expect_g(3'b001, "R8 tie to single client");
    drive(3'b100, 2'b11, 24'h0);
    drive(3'b100, 2'b11, 24'h0);
    expect_g(3'b100, "R8 dual served after release");
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);

    // R7: alternating single clients must not starve the dual client
    served = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (gnt[2]) served = 1'b1;
      drive({!served, ((i + 3) % 6) < 4, (i % 6) < 4}, 2'b11, 24'(i));
    end
    check(served, "R7 dual client served during alternation", 32'(served), 1);
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);

    // R7: full count has no effect while dual client is idle
    for (int k = 0; k < K + 2; k++) begin
      drive(3'b001, 2'b11, 24'(k + 1));
      expect_g(3'b001, "R7 no block while dual idle");
      drive(3'b000, 2'b11, 24'h0);
    end

    // R8: at threshold the tie goes to the dual client
    drive(3'b101, 2'b11, 24'h0);
    expect_g(3'b100, "R8 tie to dual at threshold");
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);

    // R11: unavailable resource is not granted
    drive(3'b001, 2'b10, 24'h0000_5a);
    expect_g(3'b000, "R11 A unavailable");
    drive(3'b101, 2'b10, 24'h0000_5a);
    drive(3'b001, 2'b11, 24'h0000_6b);
    expect_g(3'b001, "R11 A granted once available");
    // R9: attribute captured at grant, later changes ignored
    drive(3'b001, 2'b11, 24'h0000_ff);
    @(posedge clk); #2;
    check(attr_held[7:0] === 8'h6b, "R9 attribute held", 32'(attr_held[7:0]), 32'h6b);
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);
    drive(3'b000, 2'b11, 24'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule